// File: doc/BRIEF.md
# Short-Descriptor Access Permission Checker

This block decides, for one memory access to an already translated page, whether the access may proceed. It applies a per-domain access-control word, the page's access-permission code, the second-stage read/write permissions and the execute-never rules. It returns a grant, or a fault of the right type. A fault is either a prefetch abort for an instruction fetch or a data abort for any other access. A separate flag marks faults that come from the domain stage.

All decoding is combinational. The four results are registered, so each access presented on one rising edge is answered after that edge. There is no state other than the output register. Any pattern of inputs may be applied on every cycle.

Top module: `perm_guard`

## Requirements
- R1: The 4-bit domain number `dom_idx` selects bits `[2*dom_idx+1 : 2*dom_idx]` of `dom_ctl`. When `lng`=0 and that pair is 0 or 2, the access faults and `dom_fault`=1. In every other case `dom_fault`=0.
- R2: A domain fault is reported on `pabt` when `fetch`=1 and on `dabt` when `fetch`=0.
- R3: When `lng`=0 and the selected pair is 3 (manager), the access is granted with no permission, stage-2 or execute-never check.
- R4: When `lng`=1, the domain word is ignored and the access is checked as client. The effective AP value is `ap` with bit 0 forced to 1 whenever `afe`=1 or `lng`=1.
- R5: The effective AP values behave as follows. AP=1 aborts unprivileged accesses. AP=2 aborts unprivileged writes, and the page counts as writable only for privileged accesses. AP=3 never aborts.
- R6: AP=4 always aborts. AP=5 aborts unprivileged accesses and all writes. AP=6 and AP=7 abort all writes.
- R7: AP=0 takes its rule from `rs`. `rs`=0 aborts every access. `rs`=1 aborts writes and unprivileged accesses. `rs`=2 aborts writes only. `rs`=3 aborts every access.
- R8: A non-fetch access gets a data abort if the AP rule aborts it. It also gets a data abort from the stage-2 check: a write with `hap[1]`=0, or a read with `hap[0]`=0.
- R9: A fetch gets a prefetch abort if any of these holds: the AP rule aborts it; `xn`=1; the page is writable and `wxn`=1; the effective AP is 3 with `uwxn`=1 and `priv`=1; or `lng`, `pxn` and `priv` are all 1.
- R10: After each edge out of reset, exactly one of `grant` and (`pabt` or `dabt`) is high. `pabt` is never high for a non-fetch access, and `dabt` is never high for a fetch.
- R11: While `rst_n` is low, all outputs are 0. Otherwise, the outputs reflect the inputs sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dom_idx | input | 4 | Domain number of the page |
| dom_ctl | input | 32 | Domain access word, two bits per domain |
| ap | input | 3 | Access-permission code of the page |
| hap | input | 2 | Stage-2 permissions: bit 1 write, bit 0 read |
| xn | input | 1 | Page is execute-never |
| pxn | input | 1 | Page is privileged execute-never |
| lng | input | 1 | Entry uses the long format |
| afe | input | 1 | Access-flag mode, forces AP bit 0 |
| rs | input | 2 | Rule select for AP=0 |
| wxn | input | 1 | Writable implies execute-never |
| uwxn | input | 1 | Unprivileged-writable implies privileged execute-never |
| wr | input | 1 | Access is a write |
| fetch | input | 1 | Access is an instruction fetch |
| priv | input | 1 | Access is privileged |
| grant | output | 1 | Access allowed |
| dom_fault | output | 1 | Fault came from the domain stage |
| pabt | output | 1 | Prefetch-abort fault |
| dabt | output | 1 | Data-abort fault |

## Verification
The assertions assume that an instruction fetch is never also a write, so `wr` and `fetch` are not both high. The sweeps therefore form each access from the three legal kinds: read, write and fetch. Under that assumption every other input combination is legal. The permission sweep keeps every domain as client. It covers all combinations of AP, `afe`, `lng`, `rs`, `hap`, privilege and the execute-never controls. A separate sweep places each domain code at each of the 16 positions, with the other positions filled with the opposite code.

// File: rtl/perm_guard.sv
module perm_guard (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  dom_idx,
  input  logic [31:0] dom_ctl,
  input  logic [2:0]  ap,
  input  logic [1:0]  hap,
  input  logic        xn,
  input  logic        pxn,
  input  logic        lng,
  input  logic        afe,
  input  logic [1:0]  rs,
  input  logic        wxn,
  input  logic        uwxn,
  input  logic        wr,
  input  logic        fetch,
  input  logic        priv,
  output logic        grant,
  output logic        dom_fault,
  output logic        pabt,
  output logic        dabt
);

  logic [1:0] dom_code;
  logic [2:0] apx;
  logic       ap_abt, wrable;
  logic       dom_bad, dom_mgr, hap_abt, xn_eff, fetch_flt, data_flt;
  logic       nxt_pabt, nxt_dabt;

  assign dom_code = dom_ctl[{dom_idx, 1'b0} +: 2];
  assign dom_bad  = !lng && !dom_code[0];
  assign dom_mgr  = !lng && (dom_code == 2'b11);
  assign apx      = {ap[2:1], ap[0] | afe | lng};

  always_comb begin
    ap_abt = 1'b0;
    wrable = 1'b1;
    case (apx)
      3'd0: case (rs)
              2'd1:    ap_abt = wr || !priv;
              2'd2:    ap_abt = wr;
              default: ap_abt = 1'b1;
            endcase
      3'd1: ap_abt = !priv;
      3'd2: begin
              ap_abt = !priv && wr;
              wrable = priv;
            end
      3'd3: ap_abt = 1'b0;
      3'd4: ap_abt = 1'b1;
      3'd5: ap_abt = !priv || wr;
      default: ap_abt = wr;
    endcase
  end

  assign hap_abt   = wr ? !hap[1] : !hap[0];
  assign xn_eff    = xn || (wrable && wxn) || ((apx == 3'd3) && uwxn && priv);
  assign fetch_flt = ap_abt || xn_eff || (lng && pxn && priv);
  assign data_flt  = ap_abt || hap_abt;

  assign nxt_pabt = fetch  && (dom_bad || (!dom_mgr && fetch_flt));
  assign nxt_dabt = !fetch && (dom_bad || (!dom_mgr && data_flt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant     <= 1'b0;
      dom_fault <= 1'b0;
      pabt      <= 1'b0;
      dabt      <= 1'b0;
    end else begin
      grant     <= !(nxt_pabt || nxt_dabt);
      dom_fault <= dom_bad;
      pabt      <= nxt_pabt;
      dabt      <= nxt_dabt;
    end
  end

endmodule

// File: rtl/perm_guard_chk.sv
module perm_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  dom_idx,
  input logic [31:0] dom_ctl,
  input logic [2:0]  ap,
  input logic [1:0]  hap,
  input logic        xn,
  input logic        pxn,
  input logic        lng,
  input logic        afe,
  input logic [1:0]  rs,
  input logic        wxn,
  input logic        uwxn,
  input logic        wr,
  input logic        fetch,
  input logic        priv,
  input logic        grant,
  input logic        dom_fault,
  input logic        pabt,
  input logic        dabt
);

  p_one_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $countones({grant, pabt | dabt}) == 1);

  p_pabt_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pabt |-> $past(fetch));

  p_dabt_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dabt |-> !$past(fetch));

  p_dom_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dom_fault |-> ($past(!lng) && !$past(dom_ctl[{dom_idx, 1'b0}])));

  p_dom_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dom_fault |-> (pabt || dabt));

  p_manager_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(!lng && dom_ctl[{dom_idx, 1'b0} +: 2] == 2'b11)) |-> grant);

  p_stage2_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(lng && !fetch && wr && !hap[1])) |-> dabt);

  p_xn_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(lng && fetch && xn)) |-> pabt);

  p_reset_r11: assert property (@(posedge clk)
    !rst_n |-> !(grant || dom_fault || pabt || dabt));

endmodule

bind perm_guard perm_guard_chk u_chk (.*);

// File: tb/perm_guard_test.sv
module perm_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  dom_idx = '0;
  logic [31:0] dom_ctl = 32'h5555_5555;
  logic [2:0]  ap = '0;
  logic [1:0]  hap = 2'b11;
  logic        xn = 0, pxn = 0, lng = 0, afe = 0, wxn = 0, uwxn = 0;
  logic [1:0]  rs = '0;
  logic        wr = 0, fetch = 0, priv = 0;
  logic        grant, dom_fault, pabt, dabt;
  int          checks = 0, errors = 0, cycles = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  perm_guard uut (.*);

  function automatic logic [3:0] model();
    logic [1:0] code;
    logic [2:0] e;
    logic abt, wrb, hapa, xne, pf, df;
    code = dom_ctl[dom_idx*2 +: 2];
    if (!lng && (code == 2'd0 || code == 2'd2)) return {1'b0, 1'b1, fetch, !fetch};
    if (!lng && code == 2'd3) return 4'b1000;
    e = ap;
    if (afe || lng) e[0] = 1'b1;
    wrb = 1'b1;
    case (e)
      0: abt = (rs == 1) ? (wr || !priv) : (rs == 2) ? wr : 1'b1;
      1: abt = !priv;
      2: begin abt = !priv && wr; wrb = priv; end
      3: abt = 1'b0;
      4: abt = 1'b1;
      5: abt = !priv || wr;
      default: abt = wr;
    endcase
    hapa = wr ? !hap[1] : !hap[0];
    xne = xn || (wrb && wxn) || (e == 3 && uwxn && priv);
    pf = fetch && (abt || xne || (lng && pxn && priv));
    df = !fetch && (abt || hapa);
    return {!(pf || df), 1'b0, pf, df};
  endfunction

  function automatic string tag();
    logic [1:0] code;
    code = dom_ctl[dom_idx*2 +: 2];
    if (!lng && code != 2'd1) return (code == 2'd3) ? "R3" : (fetch ? "R2" : "R1");
    if (fetch) return "R9";
    if (wr ? !hap[1] : !hap[0]) return "R8";
    if ((afe || lng) && !ap[0]) return "R4";
    if (ap == 0) return "R7";
    return (ap < 4) ? "R5" : "R6";
  endfunction

  task automatic apply();
    logic [3:0] exp;
    string t;
    exp = model();
    t = tag();
    @(negedge clk);
    checks++;
    if ({grant, dom_fault, pabt, dabt} !== exp) begin
      errors++;
      $display("FAIL %s: got g/d/p/a=%b expected %b (ap=%0d rs=%0d lng=%b afe=%b wr=%b f=%b pv=%b)",
               t, {grant, dom_fault, pabt, dabt}, exp, ap, rs, lng, afe, wr, fetch, priv);
    end
    if ($countones({grant, pabt | dabt}) != 1 || (pabt && !fetch) || (dabt && fetch)) begin
      errors++;
      $display("FAIL R10: got g/p/a=%b%b%b expected exactly one result matching kind", grant, pabt, dabt);
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({grant, dom_fault, pabt, dabt} !== 4'b0000) begin
      errors++;
      $display("FAIL R11: got %b expected 0000 in reset", {grant, dom_fault, pabt, dabt});
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3: each code at each domain position, other fields opposite
    ap = 3'd3; hap = 2'b11; priv = 1'b1;
    for (int i = 0; i < 16; i++)
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 3; k++) begin
          dom_idx = i[3:0];
          dom_ctl = {16{~c[1:0]}};
          dom_ctl[i*2 +: 2] = c[1:0];
          wr = (k == 1); fetch = (k == 2);
          xn = (k == 2);
          lng = 1'b0;
          @(negedge clk); apply();
          lng = 1'b1;
          @(negedge clk); apply();
        end

    // R4-R9: full permission sweep with client domains
    dom_ctl = 32'h5555_5555; dom_idx = 4'd7;
    for (int a = 0; a < 8; a++)
      for (int f = 0; f < 128; f++)
        for (int k = 0; k < 3; k++)
          for (int h = 0; h < 4; h++)
            for (int r = 0; r < 4; r++) begin
              if ((f >> 5) != 0 && r != 0 && a != 0) continue;
              ap = a[2:0]; hap = h[1:0]; rs = r[1:0];
              {afe, lng, priv, xn, pxn, wxn, uwxn} = f[6:0];
              wr = (k == 1); fetch = (k == 2);
              @(negedge clk); apply();
            end

    // R11: reset clears a pending grant
    ap = 3'd3; lng = 1'b1; wr = 0; fetch = 0; hap = 2'b11;
    @(negedge clk); apply();
    rst_n = 1'b0;
    #1;
    checks++;
    if ({grant, dom_fault, pabt, dabt} !== 4'b0000) begin
      errors++;
      $display("FAIL R11: got %b expected 0000 after reset", {grant, dom_fault, pabt, dabt});
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule